// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority, and signals a single interrupt output to a processor. Software reaches it through two byte-wide addresses. Address 0 is the command port and address 1 is the data and mask port. A command byte of 0x11 starts a three-word setup sequence on the data port. That sequence sets the vector base, the cascade wiring and the end-of-interrupt style. After setup, the processor acknowledges with a one-cycle pulse and receives an 8-bit vector one cycle later.

The controller keeps three registers: pending requests, levels in service, and a mask. Either of the first two can be read through the command port. A specific end-of-interrupt command retires one in-service level, which allows nested servicing. In automatic end-of-interrupt mode the in-service register is left untouched at acknowledge. When an acknowledge finds no qualifying request, the controller returns the level-7 vector and records nothing. The `slave_mode` pin makes the instance act as the master or as a chained secondary controller. Any second instance sits outside this block.

Top module: `cascade_pic`

## Requirements
- R1: After reset the mask reads 0xFF at address 1, a command-port read returns the pending register (which reads 0 with no request), and `int_out` is low.
- R2: A command write of 0x11 clears the mask to 0x00, the in-service register and the pending register, and selects pending readback. The next three data writes are taken as the vector base, then the cascade byte, then the mode byte. `int_out` stays low until the mode byte has been written.
- R3: An acknowledged level n yields `vector_out` = vector base + n.
- R4: With `slave_mode`=0, `cascade_map` equals the cascade byte and `cascade_id` is 0. With `slave_mode`=1, `cascade_id` equals bits [2:0] of the cascade byte and `cascade_map` is 0.
- R5: After setup, a data write loads the mask and a data read returns it. A masked level never raises `int_out`, and a mask of 0xFF blocks every level.
- R6: A rising edge on `irq_in[n]` sets pending bit n, whatever the mask. The bit clears when the line is low or when level n is acknowledged.
- R7: Level 0 has the highest priority. `int_out` is high only when the highest-priority unmasked pending level is strictly higher in priority than every in-service level.
- R8: At an `irq_ack` pulse, the winning level leaves the pending register and, when automatic end-of-interrupt is off, enters the in-service register. `vector_valid` is high in the cycle after the pulse.
- R9: A command byte of 0x60+n (n in 0..7) clears in-service bit n only.
- R10: Command 0x0A selects pending readback and 0x0B selects in-service readback at address 0. The selection persists across other commands.
- R11: When bit 1 of the mode byte is set, an acknowledge leaves the in-service register unchanged.
- R12: An acknowledge with no qualifying request yields vector base + 7 and leaves the in-service register unchanged, even when level 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 0: master role, 1: chained secondary role |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 1 | 0: command port, 1: data/mask port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the address on `host_addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines, level 0 to 7 |
| irq_ack | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Vector for the last acknowledge |
| vector_valid | output | 1 | High in the cycle after an acknowledge |
| cascade_map | output | 8 | Inputs that carry a secondary controller (master role) |
| cascade_id | output | 3 | Cascade identity (secondary role) |

## Verification
The bound checker watches several behaviours on every cycle. It checks that the interrupt output stays quiet before setup completes and under a full mask. It checks that every acknowledge produces a vector one cycle later, that a spurious acknowledge returns the level-7 vector, and that a specific end-of-interrupt clears its level. It also checks that automatic end-of-interrupt leaves the in-service register alone. Other behaviours only show up in the bench's scenarios. These are the exact vector values, nested preemption and its release by specific end-of-interrupt, persistent readback selection, cascade decoding in both roles, and long random mixes of edges, masks, acknowledges and retirements checked against a reference model.

// File: rtl/pic_pkg.sv
// Package: shared constants and types for the cascadable interrupt controller.
// Assumes an 8-line controller with byte-wide host access.
package pic_pkg;
    localparam int PIC_LINES = 8;
    localparam int PIC_LVL_W = $clog2(PIC_LINES);
    localparam int PIC_DW    = 8;
    localparam int PIC_ID_W  = 3;

    localparam logic [PIC_DW-1:0] CMD_INIT    = 8'h11;
    localparam logic [PIC_DW-1:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [PIC_DW-1:0] CMD_SEL_ISR = 8'h0B;
    localparam logic [PIC_DW-1:0] CMD_EOI     = 8'h60;
    localparam int                MODE_AUTO_BIT = 1;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_BASE = 3'd1,
        ST_CASC = 3'd2,
        ST_MODE = 3'd3,
        ST_RUN  = 3'd4
    } setup_state_t;
endpackage

// File: rtl/pic_host_regs.sv
// Module: host-side command decoder and setup sequencer.
// Decodes command-port bytes (setup start, readback select, specific EOI),
// steps through the three setup words on the data port and holds the mask,
// vector base, cascade byte and mode. Assumes at most one write per cycle.
module pic_host_regs
    import pic_pkg::*;
#(
    parameter int LINES = PIC_LINES,
    parameter int DW    = PIC_DW,
    parameter int LVL_W = $clog2(LINES),
    parameter int ID_W  = PIC_ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_mode,
    input  logic             wr,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic             ready,
    output logic [LINES-1:0] imr,
    output logic [DW-1:0]    base,
    output logic [DW-1:0]    casc_map,
    output logic [ID_W-1:0]  casc_id,
    output logic             auto_eoi,
    output logic             sel_isr,
    output logic             eoi_valid,
    output logic [LVL_W-1:0] eoi_level,
    output logic             init_pulse
);
    localparam logic [DW-1:0] LVL_FIELD = DW'(LINES - 1);

    setup_state_t    state;
    logic [DW-1:0]   casc_byte;
    logic            cmd_wr;
    logic            data_wr;

    // Purpose: split host writes by target port.
    always_comb begin
        cmd_wr  = wr && !addr;
        data_wr = wr && addr;
    end

    // Purpose: decode one-cycle command strobes.
    always_comb begin
        init_pulse = cmd_wr && (wdata == CMD_INIT);
        eoi_valid  = cmd_wr && (state == ST_RUN) && ((wdata & ~LVL_FIELD) == CMD_EOI);
        eoi_level  = wdata[LVL_W-1:0];
        ready      = (state == ST_RUN);
    end

    // Purpose: setup sequencer plus mask, base, cascade, mode and readback select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            imr       <= '1;
            base      <= '0;
            casc_byte <= '0;
            auto_eoi  <= 1'b0;
            sel_isr   <= 1'b0;
        end else if (init_pulse) begin
            state    <= ST_BASE;
            imr      <= '0;
            auto_eoi <= 1'b0;
            sel_isr  <= 1'b0;
        end else if (cmd_wr && state == ST_RUN) begin
            if (wdata == CMD_SEL_IRR)      sel_isr <= 1'b0;
            else if (wdata == CMD_SEL_ISR) sel_isr <= 1'b1;
        end else if (data_wr) begin
            case (state)
                ST_BASE: begin base <= wdata;      state <= ST_CASC; end
                ST_CASC: begin casc_byte <= wdata; state <= ST_MODE; end
                ST_MODE: begin auto_eoi <= wdata[MODE_AUTO_BIT]; state <= ST_RUN; end
                ST_RUN:  imr <= wdata[LINES-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: interpret the cascade byte according to the role pin.
    always_comb begin
        casc_map = slave_mode ? '0 : casc_byte;
        casc_id  = slave_mode ? casc_byte[ID_W-1:0] : '0;
    end
endmodule

// File: rtl/pic_request.sv
// Module: edge-sensed request register.
// One slice per line: a rising edge sets the pending bit, which holds
// while the line stays high and drops when the line falls, when the level
// is granted, or when setup restarts. Assumes synchronous request lines.
module pic_request #(
    parameter int LINES = 8,
    parameter int LVL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             clear_all,
    input  logic             grant_valid,
    input  logic [LVL_W-1:0] grant_level,
    output logic [LINES-1:0] irr
);
    for (genvar g = 0; g < LINES; g++) begin : g_slice
        logic prev_q;
        logic taken;

        // Purpose: flag this slice as the one granted this cycle.
        always_comb taken = grant_valid && (grant_level == LVL_W'(g));

        // Purpose: track the line and update the pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                irr[g] <= 1'b0;
            end else begin
                prev_q <= lines[g];
                if (clear_all || taken) irr[g] <= 1'b0;
                else                    irr[g] <= lines[g] && (irr[g] || !prev_q);
            end
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// Module: priority resolver, in-service register and vector output.
// Fixed priority with level 0 highest. A request interrupts only when it
// outranks every in-service level. An acknowledge without a qualifying
// request returns the level-7 vector and records nothing.
module pic_resolver #(
    parameter int LINES = 8,
    parameter int DW    = 8,
    parameter int LVL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] imr,
    input  logic             ready,
    input  logic             auto_eoi,
    input  logic [DW-1:0]    base,
    input  logic             ack,
    input  logic             eoi_valid,
    input  logic [LVL_W-1:0] eoi_level,
    input  logic             clear_all,
    output logic [LINES-1:0] isr,
    output logic             int_out,
    output logic             grant_valid,
    output logic [LVL_W-1:0] grant_level,
    output logic [DW-1:0]    vector_out,
    output logic             vector_valid
);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(LINES - 1);

    logic [LINES-1:0] req;
    logic [LINES-1:0] upto;
    logic             win_found;
    logic [LVL_W-1:0] win;
    logic             blocked;

    // Purpose: pick the lowest-numbered unmasked pending level.
    always_comb begin
        req       = irr & ~imr;
        win_found = 1'b0;
        win       = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_found = 1'b1;
                win       = LVL_W'(i);
            end
        end
    end

    // Purpose: block the winner if an equal or higher level is in service.
    always_comb begin
        for (int i = 0; i < LINES; i++) upto[i] = (LVL_W'(i) <= win);
        blocked     = |(isr & upto);
        int_out     = ready && win_found && !blocked;
        grant_valid = ack && int_out;
        grant_level = win;
    end

    // Purpose: maintain the in-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            isr <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (grant_valid && !auto_eoi && win == LVL_W'(i)) isr[i] <= 1'b1;
                else if (eoi_valid && eoi_level == LVL_W'(i))     isr[i] <= 1'b0;
            end
        end
    end

    // Purpose: register the vector for each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector_out   <= '0;
            vector_valid <= 1'b0;
        end else begin
            vector_valid <= ack;
            if (ack) vector_out <= base + DW'(grant_valid ? win : SPUR_LVL);
        end
    end
endmodule

// File: rtl/cascade_pic.sv
// Module: top of the cascadable eight-input interrupt controller.
// Wires the host register block, the request register and the resolver,
// and muxes the host read byte. Assumes synchronous host and request inputs.
module cascade_pic
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slave_mode,
    input  logic                 host_wr,
    input  logic                 host_addr,
    input  logic [PIC_DW-1:0]    host_wdata,
    output logic [PIC_DW-1:0]    host_rdata,
    input  logic [PIC_LINES-1:0] irq_in,
    input  logic                 irq_ack,
    output logic                 int_out,
    output logic [PIC_DW-1:0]    vector_out,
    output logic                 vector_valid,
    output logic [PIC_DW-1:0]    cascade_map,
    output logic [PIC_ID_W-1:0]  cascade_id
);
    logic                 ready;
    logic [PIC_LINES-1:0] imr;
    logic [PIC_LINES-1:0] irr;
    logic [PIC_LINES-1:0] isr;
    logic [PIC_DW-1:0]    base;
    logic                 auto_eoi;
    logic                 sel_isr;
    logic                 eoi_valid;
    logic [PIC_LVL_W-1:0] eoi_level;
    logic                 init_pulse;
    logic                 grant_valid;
    logic [PIC_LVL_W-1:0] grant_level;

    pic_host_regs u_regs (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
        .ready(ready), .imr(imr), .base(base),
        .casc_map(cascade_map), .casc_id(cascade_id),
        .auto_eoi(auto_eoi), .sel_isr(sel_isr),
        .eoi_valid(eoi_valid), .eoi_level(eoi_level), .init_pulse(init_pulse)
    );

    pic_request #(.LINES(PIC_LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .clear_all(init_pulse),
        .grant_valid(grant_valid), .grant_level(grant_level), .irr(irr)
    );

    pic_resolver #(.LINES(PIC_LINES), .DW(PIC_DW)) u_res (
        .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .ready(ready),
        .auto_eoi(auto_eoi), .base(base), .ack(irq_ack),
        .eoi_valid(eoi_valid), .eoi_level(eoi_level), .clear_all(init_pulse),
        .isr(isr), .int_out(int_out), .grant_valid(grant_valid),
        .grant_level(grant_level), .vector_out(vector_out), .vector_valid(vector_valid)
    );

    // Purpose: host read mux for the two addresses.
    always_comb begin
        if (host_addr) host_rdata = imr;
        else           host_rdata = sel_isr ? isr : irr;
    end
endmodule

// File: rtl/pic_checker.sv
// Module: assertion checker bound into cascade_pic.
// Observes ports and internal register state; drives nothing.
module pic_checker #(
    parameter int LINES = 8,
    parameter int DW    = 8,
    parameter int LVL_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic [LINES-1:0] imr,
    input logic [LINES-1:0] isr,
    input logic [DW-1:0]    base,
    input logic             auto_eoi,
    input logic             eoi_valid,
    input logic [LVL_W-1:0] eoi_level,
    input logic             init_pulse,
    input logic             ack,
    input logic             int_out,
    input logic [DW-1:0]    vector_out,
    input logic             vector_valid
);
    a_r2_quiet_before_setup: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    a_r5_full_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (imr == '1) |-> !int_out);

    a_r8_vector_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vector_valid);

    a_r8_no_stray_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> $past(ack));

    a_r9_eoi_clears_level: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !isr[$past(eoi_level)]);

    a_r11_auto_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && auto_eoi && ack && !eoi_valid && !init_pulse) |=> (isr == $past(isr)));

    a_r12_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> (vector_out == $past(base) + DW'(LINES - 1)));
endmodule

bind cascade_pic pic_checker #(.LINES(pic_pkg::PIC_LINES), .DW(pic_pkg::PIC_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .imr(imr), .isr(isr), .base(base),
    .auto_eoi(auto_eoi), .eoi_valid(eoi_valid), .eoi_level(eoi_level),
    .init_pulse(init_pulse), .ack(irq_ack), .int_out(int_out),
    .vector_out(vector_out), .vector_valid(vector_valid)
);

// File: tb/sim_cascade_pic.sv
// Bench for cascade_pic: directed corner cases, then seeded random traffic
// compared against a behavioural model built from the requirements.
module sim_cascade_pic;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       irq_ack = 1'b0;
    logic       int_out;
    logic [7:0] vector_out;
    logic       vector_valid;
    logic [7:0] cascade_map;
    logic [2:0] cascade_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    cascade_pic u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_in(irq_in), .irq_ack(irq_ack),
        .int_out(int_out), .vector_out(vector_out), .vector_valid(vector_valid),
        .cascade_map(cascade_map), .cascade_id(cascade_id)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0; host_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
        host_addr = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    // Model: winning level among unmasked pending bits (level 0 highest).
    function automatic int f_winner(input logic [7:0] req);
        for (int i = 0; i < 8; i++) if (req[i]) return i;
        return -1;
    endfunction

    // Model: expected interrupt output.
    function automatic logic f_int(input logic [7:0] irr, input logic [7:0] imr, input logic [7:0] isr);
        int w = f_winner(irr & ~imr);
        if (w < 0) return 1'b0;
        for (int i = 0; i <= w; i++) if (isr[i]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] m_irr, m_isr, m_imr, m_prev, m_base;
        logic       exp_vec_valid;
        logic [7:0] exp_vec;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(1'b1, d); chk("R1 mask after reset", d, 8'hFF);
        rd(1'b0, d); chk("R1 pending readback after reset", d, 8'h00);
        chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);

        // R2/R4: setup as master
        wr(1'b0, 8'h11);
        rd(1'b1, d); chk("R2 mask cleared by setup", d, 8'h00);
        wr(1'b1, 8'h40);
        irq_in[3] = 1'b1; tick();
        chk("R2 quiet during setup", {7'd0, int_out}, 8'h00);
        irq_in[3] = 1'b0; tick();
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        chk("R4 master cascade map", cascade_map, 8'h04);
        chk("R4 master cascade id", {5'd0, cascade_id}, 8'h00);
        chk("R2 idle after setup", {7'd0, int_out}, 8'h00);

        // R5/R6: mask behaviour and pending capture
        wr(1'b1, 8'hFF);
        rd(1'b1, d); chk("R5 mask readback", d, 8'hFF);
        irq_in[5] = 1'b1; tick();
        chk("R5 full mask blocks", {7'd0, int_out}, 8'h00);
        rd(1'b0, d); chk("R6 pending despite mask", d, 8'h20);
        wr(1'b1, 8'h00);
        chk("R5 unmask raises int", {7'd0, int_out}, 8'h01);
        irq_in[5] = 1'b0; tick();
        chk("R6 pending drops with line", {7'd0, int_out}, 8'h00);
        rd(1'b0, d); chk("R6 pending cleared", d, 8'h00);

        // R3/R7/R8/R9/R10: nested priority
        irq_in[4] = 1'b1; tick();
        chk("R7 single request", {7'd0, int_out}, 8'h01);
        ack_pulse();
        chk("R8 vector_valid", {7'd0, vector_valid}, 8'h01);
        chk("R3 vector level 4", vector_out, 8'h44);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 in-service level 4", d, 8'h10);
        chk("R8 no int after ack", {7'd0, int_out}, 8'h00);
        irq_in[6] = 1'b1; tick();
        chk("R7 lower level blocked", {7'd0, int_out}, 8'h00);
        irq_in[1] = 1'b1; tick();
        chk("R7 higher level preempts", {7'd0, int_out}, 8'h01);
        ack_pulse();
        chk("R3 vector level 1", vector_out, 8'h41);
        rd(1'b0, d); chk("R8 nested in-service", d, 8'h12);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R9 eoi level 1 only", d, 8'h10);
        chk("R7 level 6 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h64);
        rd(1'b0, d); chk("R9 eoi level 4", d, 8'h00);
        chk("R7 level 6 released", {7'd0, int_out}, 8'h01);
        ack_pulse();
        chk("R3 vector level 6", vector_out, 8'h46);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R10 select persists", d, 8'h40);
        wr(1'b0, 8'h66);
        rd(1'b0, d); chk("R9 eoi level 6", d, 8'h00);
        irq_in = 8'h00; tick();

        // R10/R12: spurious acknowledge with level 7 masked
        wr(1'b1, 8'h80);
        irq_in[2] = 1'b1; tick();
        chk("R12 request seen", {7'd0, int_out}, 8'h01);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R10 pending select", d, 8'h04);
        irq_in[2] = 1'b0; tick();
        ack_pulse();
        chk("R12 spurious vector", vector_out, 8'h47);
        chk("R12 spurious valid", {7'd0, vector_valid}, 8'h01);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R12 in-service untouched", d, 8'h00);

        // R2/R4/R11: re-setup as secondary with automatic EOI
        slave_mode = 1'b1;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h02);
        chk("R4 slave cascade id", {5'd0, cascade_id}, 8'h02);
        chk("R4 slave cascade map", cascade_map, 8'h00);
        irq_in[0] = 1'b1; tick();
        chk("R2 quiet before mode byte", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h03);
        chk("R2 active after mode byte", {7'd0, int_out}, 8'h01);
        ack_pulse();
        chk("R11 vector level 0", vector_out, 8'h20);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R11 in-service stays clear", d, 8'h00);
        irq_in = 8'h00; tick(); tick();

        // Random phase against the model: master, normal EOI, base 0x80
        slave_mode = 1'b0;
        wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        wr(1'b0, 8'h0B);
        m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_base = 8'h80;
        exp_vec_valid = 0; exp_vec = 0;
        void'($urandom(32'd20240611));
        for (int it = 0; it < 3000; it++) begin
            logic       e_int, grant, do_ack, do_eoi, do_mask;
            logic [7:0] nl, nirr, mval;
            int         w, act;
            logic [2:0] lvl;
            e_int = f_int(m_irr, m_imr, m_isr);
            chk("R7 random int_out", {7'd0, int_out}, {7'd0, e_int});
            rd(1'b0, d); chk("R8 random in-service", d, m_isr);
            if (exp_vec_valid) chk("R3 random vector", vector_out, exp_vec);
            act = int'($urandom % 8);
            nl = irq_in;
            if ($urandom % 3 == 0) nl[$urandom % 8] = ~nl[$urandom % 8];
            do_ack  = (act == 3 || act == 4);
            do_eoi  = (act == 5);
            do_mask = (act == 6);
            lvl  = 3'($urandom % 8);
            mval = 8'($urandom & $urandom & $urandom);
            w = f_winner(m_irr & ~m_imr);
            grant = do_ack && e_int;
            nirr = nl & (m_irr | ~m_prev);
            if (grant) begin nirr[w] = 1'b0; m_isr[w] = 1'b1; end
            if (do_eoi) m_isr[lvl] = 1'b0;
            if (do_mask) m_imr = mval;
            exp_vec_valid = do_ack;
            exp_vec = grant ? m_base + 8'(w) : m_base + 8'd7;
            m_irr = nirr; m_prev = nl;
            irq_in = nl;
            irq_ack = do_ack;
            if (do_eoi) begin host_addr = 1'b0; host_wdata = {5'b01100, lvl}; host_wr = 1'b1; end
            if (do_mask) begin host_addr = 1'b1; host_wdata = mval; host_wr = 1'b1; end
            tick();
            irq_ack = 1'b0; host_wr = 1'b0; host_addr = 1'b0;
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule